// File: doc/BRIEF.md
# Frame SECDED Syndrome Accumulator

This block checks one configuration frame for upset bits while the frame streams past, one 32-bit word per clock. The frame already holds its own check bits, so the block needs no encoder. It runs a single-error-correct, double-error-detect syndrome over every bit it sees, and that includes the stored check bits. Each bit carries a position code made from its word index and its bit index. The running syndrome XORs in the code of every set bit, and it also keeps the XOR of all the bits as an overall parity.

When the word marked as last has been taken in, the block registers a 13-bit syndrome and pulses a valid strobe. It also reports whether the frame has any error and whether that error is a single correctable bit. For a single error it decodes the failing word index and bit index. The block only locates errors. Any repair is left to the logic around it, which must rewrite the frame.

Top module: `frame_secded_syndrome`

## Requirements
- R1: After reset, and until the first frame completes, every output is zero.
- R2: The first accepted beat of a frame (in_sof high) is word 0, and each later accepted beat raises the word index by one. Bit b of word k has position code k*32+b. syndrome[11:0] is the XOR of the position codes of all set bits, and syndrome[12] is the XOR of all bits.
- R3: A consistent frame gives syndrome 0, err_any 0 and err_single 0.
- R4: A single flipped bit, in data or in check bits, gives syndrome[12]=1 and syndrome[11:0] equal to its position code. It also raises err_any and err_single, and sets err_word to k and err_bit to b.
- R5: Two flipped bits give syndrome[12]=0 with syndrome[11:0] non-zero, err_any=1 and err_single=0. err_word and err_bit then read 0.
- R6: syn_valid is high for exactly one clock, the clock after the beat that carries in_eof. The result outputs change only then and hold until the next result.
- R7: A beat with in_sof high discards any partly gathered frame and starts again at word 0.
- R8: Clocks with in_valid low change nothing. A frame with idle gaps gives the same result as one without gaps.
- R9: A flip of the overall parity bit (word 0, bit 0, code 0) is reported as a single error at word 0, bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word beat present |
| in_sof | input | 1 | Beat is the first word of a frame |
| in_eof | input | 1 | Beat is the last word of a frame |
| in_word | input | 32 | Frame word |
| syn_valid | output | 1 | One-clock strobe: result ready |
| syndrome | output | 13 | Parity bit [12] and position [11:0] |
| err_any | output | 1 | Frame holds an error |
| err_single | output | 1 | Error is one correctable bit |
| err_word | output | 7 | Word index of a single error |
| err_bit | output | 5 | Bit index of a single error |

## Verification
The assertions assume that every frame opens with an in_sof beat, ends with one in_eof beat, and stays within 128 words, so the word index never wraps. They also assume that no more than two bits are corrupted, because beyond that the syndrome means nothing. The bench builds each frame with a 101-word encoder of its own. It then flips zero, one or two chosen bits, always starts with in_sof and ends with in_eof, and holds the control inputs low during reset and between frames.

// File: rtl/fsd_pkg.sv
package fsd_pkg;
    typedef enum logic [1:0] {
        CLS_CLEAN  = 2'd0,
        CLS_SINGLE = 2'd1,
        CLS_DOUBLE = 2'd2
    } err_class_e;
endpackage

// File: rtl/fsd_word_term.sv
module fsd_word_term #(
    parameter int WORD_W = 32,
    parameter int IDX_W  = 7,
    localparam int BIT_W = $clog2(WORD_W),
    localparam int SYN_W = IDX_W + BIT_W + 1
) (
    input  logic [WORD_W-1:0] word,
    input  logic [IDX_W-1:0]  idx,
    output logic [SYN_W-1:0]  term
);
    logic [BIT_W-1:0] masked [WORD_W];
    logic [BIT_W-1:0] lo_x;
    logic             par;

    generate
        for (genvar b = 0; b < WORD_W; b++) begin : g_mask
            assign masked[b] = word[b] ? BIT_W'(b) : '0;
        end
    endgenerate

    always_comb begin
        lo_x = '0;
        for (int i = 0; i < WORD_W; i++) begin
            lo_x = lo_x ^ masked[i];
        end
    end

    assign par  = ^word;
    assign term = {par, idx & {IDX_W{par}}, lo_x};
endmodule

// File: rtl/fsd_accum.sv
module fsd_accum #(
    parameter int WORD_W = 32,
    parameter int IDX_W  = 7,
    localparam int BIT_W = $clog2(WORD_W),
    localparam int SYN_W = IDX_W + BIT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [WORD_W-1:0] in_word,
    output logic              frame_done,
    output logic [SYN_W-1:0]  frame_syn
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [SYN_W-1:0] acc;
    } acc_st_t;

    acc_st_t          st_d, st_q;
    logic [IDX_W-1:0] base_idx;
    logic [SYN_W-1:0] base_acc;
    logic [SYN_W-1:0] term;
    logic [SYN_W-1:0] acc_new;

    assign base_idx = in_sof ? '0 : st_q.idx;
    assign base_acc = in_sof ? '0 : st_q.acc;

    fsd_word_term #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_term (
        .word (in_word),
        .idx  (base_idx),
        .term (term)
    );

    always_comb begin
        acc_new = base_acc ^ term;
        st_d    = st_q;
        if (in_valid) begin
            st_d.idx = base_idx + IDX_W'(1);
            st_d.acc = acc_new;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frame_done = in_valid & in_eof;
    assign frame_syn  = acc_new;

    // R7: a start beat restarts the word count
    p_sof_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof) |=> (st_q.idx == IDX_W'(1)));

    // R8: idle clocks leave the running state untouched
    p_gap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(st_q.idx) && $stable(st_q.acc)));
endmodule

// File: rtl/fsd_report.sv
module fsd_report
    import fsd_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int IDX_W  = 7,
    localparam int BIT_W = $clog2(WORD_W),
    localparam int POS_W = IDX_W + BIT_W,
    localparam int SYN_W = POS_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_done,
    input  logic [SYN_W-1:0] frame_syn,
    output logic             syn_valid,
    output logic [SYN_W-1:0] syndrome,
    output logic             err_any,
    output logic             err_single,
    output logic [IDX_W-1:0] err_word,
    output logic [BIT_W-1:0] err_bit
);
    typedef struct packed {
        logic             valid;
        logic [SYN_W-1:0] syn;
        logic             any;
        logic             single;
        logic [IDX_W-1:0] loc_word;
        logic [BIT_W-1:0] loc_bit;
    } rep_st_t;

    rep_st_t    st_d, st_q;
    err_class_e cls;

    always_comb begin
        if (frame_syn == '0)           cls = CLS_CLEAN;
        else if (frame_syn[SYN_W-1])   cls = CLS_SINGLE;
        else                           cls = CLS_DOUBLE;
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (frame_done) begin
            st_d.valid    = 1'b1;
            st_d.syn      = frame_syn;
            st_d.any      = (cls != CLS_CLEAN);
            st_d.single   = (cls == CLS_SINGLE);
            st_d.loc_word = '0;
            st_d.loc_bit  = '0;
            if (cls == CLS_SINGLE) begin
                st_d.loc_word = frame_syn[POS_W-1:BIT_W];
                st_d.loc_bit  = frame_syn[BIT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign syn_valid  = st_q.valid;
    assign syndrome   = st_q.syn;
    assign err_any    = st_q.any;
    assign err_single = st_q.single;
    assign err_word   = st_q.loc_word;
    assign err_bit    = st_q.loc_bit;

    // R6: strobe follows a last-word beat by one clock
    p_strobe_follows_eof_r6: assert property (@(posedge clk) disable iff (!rst_n)
        syn_valid |-> $past(frame_done));
    // R6: results hold between strobes
    p_hold_between_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !syn_valid |-> ($stable(syndrome) && $stable(err_any) && $stable(err_word)));
    // R3: zero syndrome means no error flag
    p_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (syndrome == '0) |-> (!err_any && !err_single));
    // R4: single error location matches the position field
    p_single_loc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_single |-> (err_any && syndrome[SYN_W-1] && ({err_word, err_bit} == syndrome[POS_W-1:0])));
    // R5: even-parity non-zero syndrome is an uncorrectable error
    p_double_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!syndrome[SYN_W-1] && (syndrome[POS_W-1:0] != '0)) |->
            (err_any && !err_single && err_word == '0 && err_bit == '0));
endmodule

// File: rtl/frame_secded_syndrome.sv
module frame_secded_syndrome #(
    parameter int WORD_W = 32,
    parameter int IDX_W  = 7,
    localparam int BIT_W = $clog2(WORD_W),
    localparam int SYN_W = IDX_W + BIT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [WORD_W-1:0] in_word,
    output logic              syn_valid,
    output logic [SYN_W-1:0]  syndrome,
    output logic              err_any,
    output logic              err_single,
    output logic [IDX_W-1:0]  err_word,
    output logic [BIT_W-1:0]  err_bit
);
    logic             frame_done;
    logic [SYN_W-1:0] frame_syn;

    fsd_accum #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sof     (in_sof),
        .in_eof     (in_eof),
        .in_word    (in_word),
        .frame_done (frame_done),
        .frame_syn  (frame_syn)
    );

    fsd_report #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_report (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .frame_syn  (frame_syn),
        .syn_valid  (syn_valid),
        .syndrome   (syndrome),
        .err_any    (err_any),
        .err_single (err_single),
        .err_word   (err_word),
        .err_bit    (err_bit)
    );
endmodule

// File: tb/sim_frame_secded_syndrome.sv
`timescale 1ns/1ps
module sim_frame_secded_syndrome;
    localparam int NW = 101;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [31:0] in_word = '0;
    logic        syn_valid, err_any, err_single;
    logic [12:0] syndrome;
    logic [6:0]  err_word;
    logic [4:0]  err_bit;

    int n_chk = 0, n_bad = 0;
    logic [31:0] fr [NW];

    always #2.5 clk = ~clk;

    frame_secded_syndrome u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_eof(in_eof), .in_word(in_word), .syn_valid(syn_valid),
        .syndrome(syndrome), .err_any(err_any), .err_single(err_single),
        .err_word(err_word), .err_bit(err_bit)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic flip(input int pos);
        fr[pos >> 5][pos & 31] = ~fr[pos >> 5][pos & 31];
    endtask

    task automatic put(input int pos, input logic v);
        fr[pos >> 5][pos & 31] = v;
    endtask

    // fill frame, then set check bits and overall parity per R2
    task automatic encode(input int mode);
        logic [11:0] s;
        logic        par;
        for (int w = 0; w < NW; w++)
            fr[w] = (mode == 0) ? $urandom : ((mode == 1) ? 32'hFFFF_FFFF : 32'h0000_0000);
        put(0, 1'b0);
        for (int p = 0; p < 12; p++) put(1 << p, 1'b0);
        s = '0;
        for (int w = 0; w < NW; w++)
            for (int b = 0; b < 32; b++)
                if (fr[w][b]) s = s ^ 12'(w * 32 + b);
        for (int p = 0; p < 12; p++) put(1 << p, s[p]);
        par = 1'b0;
        for (int w = 0; w < NW; w++) par = par ^ (^fr[w]);
        put(0, par);
    endtask

    task automatic send(input int gap);
        for (int w = 0; w < NW; w++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = (w == 0); in_eof = (w == NW - 1); in_word = fr[w];
            if (gap > 0 && (w % gap) == gap - 1 && w < NW - 1) begin
                @(negedge clk);
                in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_word = 32'hDEAD_BEEF;
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_word = '0;
    endtask

    // call right after send: one negedge past the eof capture edge
    task automatic expect_res(input string tag, input logic [12:0] es,
                              input logic ea, input logic esg,
                              input logic [6:0] ew, input logic [4:0] eb);
        chk({tag, " R6 strobe"}, 32'(syn_valid), 32'd1);
        chk({tag, " R2 syndrome"}, 32'(syndrome), 32'(es));
        chk({tag, " err_any"}, 32'(err_any), 32'(ea));
        chk({tag, " err_single"}, 32'(err_single), 32'(esg));
        chk({tag, " err_word"}, 32'(err_word), 32'(ew));
        chk({tag, " err_bit"}, 32'(err_bit), 32'(eb));
        @(negedge clk);
        chk({tag, " R6 strobe low"}, 32'(syn_valid), 32'd0);
        chk({tag, " R6 hold"}, 32'(syndrome), 32'(es));
    endtask

    task automatic t_reset;
        chk("R1 syn_valid", 32'(syn_valid), 0);
        chk("R1 syndrome", 32'(syndrome), 0);
        chk("R1 flags", 32'({err_any, err_single}), 0);
        chk("R1 loc", 32'({err_word, err_bit}), 0);
    endtask

    task automatic t_clean(input int mode);
        encode(mode);
        send(0);
        expect_res("R3 clean", 13'd0, 1'b0, 1'b0, 7'd0, 5'd0);
    endtask

    task automatic t_single(input int w, input int b, input string tag);
        int p = w * 32 + b;
        encode(0);
        flip(p);
        send(0);
        expect_res(tag, {1'b1, 12'(p)}, 1'b1, 1'b1, 7'(w), 5'(b));
    endtask

    task automatic t_double;
        int p1 = 10 * 32 + 3;
        int p2 = 77 * 32 + 30;
        encode(0);
        flip(p1); flip(p2);
        send(0);
        expect_res("R5 double", {1'b0, 12'(p1) ^ 12'(p2)}, 1'b1, 1'b0, 7'd0, 5'd0);
    endtask

    task automatic t_gaps;
        encode(0);
        send(3);
        expect_res("R8 gaps clean", 13'd0, 1'b0, 1'b0, 7'd0, 5'd0);
        encode(0);
        flip(33 * 32 + 9);
        send(2);
        expect_res("R8 gaps single", {1'b1, 12'(33 * 32 + 9)}, 1'b1, 1'b1, 7'd33, 5'd9);
    endtask

    task automatic t_restart;
        for (int w = 0; w < 30; w++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = (w == 0); in_eof = 1'b0; in_word = $urandom;
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0;
        chk("R7 no strobe on partial", 32'(syn_valid), 0);
        encode(0);
        send(0);
        expect_res("R7 restart", 13'd0, 1'b0, 1'b0, 7'd0, 5'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean(0);
        t_clean(1);
        t_clean(2);
        t_single(50, 17, "R4 data bit");
        t_single(2, 0, "R4 check bit");
        t_single(0, 16, "R4 low check bit");
        t_single(100, 31, "R4 last bit");
        t_single(0, 0, "R9 parity bit");
        t_double();
        t_gaps();
        t_restart();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule